// File: doc/BRIEF.md
# Dual Event Counter Unit

The unit holds two 40-bit programmable event counters for observing activity inside a core. Each clock cycle it receives a small set of event lanes. Each lane carries a valid bit, an 8-bit event code and an 8-bit unit mask. Each counter has its own event selector, which chooses the code and mask to match. The selector also decides how the number of matching lanes in a cycle is turned into an increment:

- the raw number of matching lanes is added, or
- one is added when that number meets a threshold, optionally inverted, optionally counted only on a rising edge of the condition.

Software reaches the counters, the selectors, a global enable register, a sticky overflow status register and a write-one-to-clear register through a single-cycle address/write/read port. A sampling period is programmed by preloading a counter with the two's complement of the period. When the 40-bit value wraps past all ones, the counter's status bit is set. If that counter's interrupt enable is set, the interrupt output rises. A fixed group of event codes may only be counted on counter 0; programmed into counter 1 they leave it idle.

Top module: `evt_counter_pair`

## Requirements
- R1: After reset, all counters, selectors, the global enable and the status register read as zero, and `irq` is low.
- R2: Global enable register at address 0x2f: bit i enables counter i. A counter advances only while its global bit and its selector enable (bit 22) are both set. A write takes effect at the next clock edge.
- R3: Counters are read and written at 0x20 (counter 0) and 0x21 (counter 1). Writes keep only bits 39:0. A write overrides any increment in the same cycle, and the new value is readable after that edge.
- R4: Selectors are at 0x28 and 0x29 and read back as written in bits 31:0. Their fields are: event code 7:0, unit mask 15:8, edge 18, interrupt enable 20, enable 22, invert 23, threshold 31:24. A lane matches when it is valid and its code and unit mask both equal the selector's.
- R5: With threshold zero, the counter adds the number of matching lanes each cycle. Invert and edge have no effect in this mode.
- R6: With a non-zero threshold, the counter adds 1 in each cycle where the matching-lane count is at least the threshold. With invert set, the test becomes strictly below the threshold.
- R7: With edge set and a non-zero threshold, the counter adds 1 only when the condition is true and was false in the previous cycle. The condition is taken as false in the cycle before a counter becomes active.
- R8: Event codes 0xc3, 0xc4, 0xc8-0xcc, 0xce, 0xcf, 0xd7, 0xe3, 0xe6, 0xe7, 0xf1, 0xf2, 0xf6, 0xf7 and 0xfc-0xff never advance counter 1. The same codes do count on counter 0.
- R9: When an increment carries a counter past 2^40-1, the counter keeps the low 40 bits and status bit i at 0x2d is set. Writes to 0x2d are ignored.
- R10: Writing a mask to 0x2e clears each status bit set in the mask. Address 0x2e reads zero. An overflow in the same cycle as its clear leaves the bit set.
- R11: `irq` is high exactly while some status bit is set whose counter has interrupt enable (bit 20) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_vld | input | NUM_LANES | Per-lane event valid |
| lane_code | input | 8*NUM_LANES | Per-lane event code, lane l in bits 8l+7:8l |
| lane_umask | input | 8*NUM_LANES | Per-lane unit mask, same packing |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an overflow and a clear. The bench preloads counter 0 with all ones and drives one matching lane in the same cycle as a write of 1 to the overflow-clear register. It then expects the status bit to stay set and the counter to read zero.

The second pair is a counter write and an increment. The bench writes counter 0 while two matching lanes are active, and expects the written value with no increment added.

A table of threshold, invert and edge settings runs one fixed five-cycle lane pattern, and each row is compared with a hand-computed count.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   localparam int SEL_W = 32;

   localparam logic [7:0] ADR_CNT_BASE = 8'h20;
   localparam logic [7:0] ADR_SEL_BASE = 8'h28;
   localparam logic [7:0] ADR_STATUS   = 8'h2d;
   localparam logic [7:0] ADR_OVF_CLR  = 8'h2e;
   localparam logic [7:0] ADR_GLB_CTL  = 8'h2f;

   typedef struct packed {
      logic [7:0] thresh;    // 31:24
      logic       inv;       // 23
      logic       en;        // 22
      logic       rsv21;
      logic       irq_en;    // 20
      logic       rsv19;
      logic       edge_det;  // 18
      logic [1:0] rsv17;
      logic [7:0] umask;     // 15:8
      logic [7:0] code;      // 7:0
   } evsel_t;

   // Codes that only the first counter may count
   function automatic logic ctr0_only(input logic [7:0] c);
      case (c)
         8'hc3, 8'hc4, 8'hc8, 8'hc9, 8'hca, 8'hcb, 8'hcc, 8'hce, 8'hcf,
         8'hd7, 8'he3, 8'he6, 8'he7, 8'hf1, 8'hf2, 8'hf6, 8'hf7,
         8'hfc, 8'hfd, 8'hfe, 8'hff: return 1'b1;
         default:                    return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dpc_lane_match.sv
module dpc_lane_match #(
   parameter int NUM_LANES = 4,
   parameter int NW        = 3
) (
   input  logic [NUM_LANES-1:0]   lane_vld,
   input  logic [NUM_LANES*8-1:0] lane_code,
   input  logic [NUM_LANES*8-1:0] lane_umask,
   input  logic [7:0]             sel_code,
   input  logic [7:0]             sel_umask,
   output logic [NW-1:0]          n_match
);

   logic [NUM_LANES-1:0] hit;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign hit[l] = lane_vld[l]
                      && (lane_code[l*8 +: 8]  == sel_code)
                      && (lane_umask[l*8 +: 8] == sel_umask);
   end

   always_comb begin
      n_match = '0;
      for (int l = 0; l < NUM_LANES; l++)
         n_match = n_match + NW'(hit[l]);
   end

endmodule

// File: rtl/dpc_qualify.sv
module dpc_qualify #(
   parameter int NW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [NW-1:0] n_match,
   input  logic [7:0]    thresh,
   input  logic          inv,
   input  logic          edge_det,
   output logic [NW-1:0] inc
);

   logic ge, cond, pulse, prev_q;

   assign ge    = ({8'd0, n_match} >= {{NW{1'b0}}, thresh});
   assign cond  = inv ? !ge : ge;
   assign pulse = edge_det ? (cond && !prev_q) : cond;

   always_comb begin
      if (!active)
         inc = '0;
      else if (thresh == 8'd0)
         inc = n_match;
      else
         inc = {{(NW-1){1'b0}}, pulse};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= active && cond;
   end

endmodule

// File: rtl/dpc_counter.sv
module dpc_counter #(
   parameter int CNT_W = 40,
   parameter int NW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic [NW-1:0]    inc,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);

   logic [CNT_W:0] sum;

   assign sum  = {1'b0, value} + {{(CNT_W+1-NW){1'b0}}, inc};
   assign wrap = !wr_en && sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= '0;
      else if (wr_en) value <= wr_val;
      else            value <= sum[CNT_W-1:0];
   end

endmodule

// File: rtl/evt_counter_pair.sv
module evt_counter_pair
   import dpc_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int NUM_CTR   = 2,
   parameter int CNT_W     = 40,
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LANES-1:0]   lane_vld,
   input  logic [NUM_LANES*8-1:0] lane_code,
   input  logic [NUM_LANES*8-1:0] lane_umask,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   output logic                   irq
);

   localparam int NW = $clog2(NUM_LANES + 1);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STATUS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADR_OVF_CLR);
   localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(ADR_GLB_CTL);

   if (NUM_LANES < 2 || NUM_LANES > 15) begin : g_bad_lanes
      $error("NUM_LANES must be 2..15");
   end
   if (NUM_CTR < 1 || NUM_CTR > 5) begin : g_bad_ctr
      $error("NUM_CTR must be 1..5");
   end
   if (CNT_W <= NW || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must exceed increment width and fit DATA_W");
   end
   if (DATA_W < SEL_W || ADDR_W < 6) begin : g_bad_bus
      $error("DATA_W must hold a selector and ADDR_W must reach 0x2f");
   end

   function automatic logic [ADDR_W-1:0] cnt_addr(input int i);
      return ADDR_W'(ADR_CNT_BASE) + ADDR_W'(i);
   endfunction

   function automatic logic [ADDR_W-1:0] sel_addr(input int i);
      return ADDR_W'(ADR_SEL_BASE) + ADDR_W'(i);
   endfunction

   evsel_t             sel_q   [NUM_CTR];
   logic [CNT_W-1:0]   cnt_val [NUM_CTR];
   logic [NUM_CTR-1:0] glb_en_q, status_q, wrap, code_ok, active, inten;
   logic               gctl_wr, clr_wr;

   assign gctl_wr = reg_wr && (reg_addr == A_GCTL);
   assign clr_wr  = reg_wr && (reg_addr == A_CLR);

   // Configuration and status registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CTR; i++) sel_q[i] <= '0;
         glb_en_q <= '0;
         status_q <= '0;
      end else begin
         if (gctl_wr) glb_en_q <= reg_wdata[NUM_CTR-1:0];
         for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_wr && (reg_addr == sel_addr(i)))
               sel_q[i] <= evsel_t'(reg_wdata[SEL_W-1:0]);
            if (wrap[i])
               status_q[i] <= 1'b1;
            else if (clr_wr && reg_wdata[i])
               status_q[i] <= 1'b0;
         end
      end
   end

   // Per-counter datapath
   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic [NW-1:0] n_match, inc;
      logic          cnt_wr;

      if (i == 0) begin : g_any_code
         assign code_ok[i] = 1'b1;
      end else begin : g_limited_code
         assign code_ok[i] = !ctr0_only(sel_q[i].code);
      end

      assign active[i] = glb_en_q[i] && sel_q[i].en && code_ok[i];
      assign inten[i]  = sel_q[i].irq_en;
      assign cnt_wr    = reg_wr && (reg_addr == cnt_addr(i));

      dpc_lane_match #(.NUM_LANES(NUM_LANES), .NW(NW)) u_match (
         .lane_vld  (lane_vld),
         .lane_code (lane_code),
         .lane_umask(lane_umask),
         .sel_code  (sel_q[i].code),
         .sel_umask (sel_q[i].umask),
         .n_match   (n_match)
      );

      dpc_qualify #(.NW(NW)) u_qual (
         .clk     (clk),
         .rst_n   (rst_n),
         .active  (active[i]),
         .n_match (n_match),
         .thresh  (sel_q[i].thresh),
         .inv     (sel_q[i].inv),
         .edge_det(sel_q[i].edge_det),
         .inc     (inc)
      );

      dpc_counter #(.CNT_W(CNT_W), .NW(NW)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (cnt_wr),
         .wr_val(reg_wdata[CNT_W-1:0]),
         .inc   (inc),
         .value (cnt_val[i]),
         .wrap  (wrap[i])
      );
   end

   // Read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STAT) reg_rdata[NUM_CTR-1:0] = status_q;
      if (reg_addr == A_GCTL) reg_rdata[NUM_CTR-1:0] = glb_en_q;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (reg_addr == cnt_addr(i)) reg_rdata[CNT_W-1:0] = cnt_val[i];
         if (reg_addr == sel_addr(i)) reg_rdata[SEL_W-1:0] = sel_q[i];
      end
   end

   assign irq = |(status_q & inten);

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
   import dpc_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int NUM_CTR   = 2,
   parameter int CNT_W     = 40,
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic               irq,
   input logic [NUM_CTR-1:0] status,
   input logic [NUM_CTR-1:0] glb_en,
   input logic [CNT_W-1:0]   cnt_a,
   input logic [CNT_W-1:0]   cnt_b,
   input logic [SEL_W-1:0]   sel_b
);

   localparam logic [ADDR_W-1:0] A_CNT_A = ADDR_W'(ADR_CNT_BASE);
   localparam logic [ADDR_W-1:0] A_CNT_B = ADDR_W'(ADR_CNT_BASE) + ADDR_W'(NUM_CTR-1);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(ADR_OVF_CLR);
   localparam logic [ADDR_W-1:0] A_GCTL  = ADDR_W'(ADR_GLB_CTL);
   localparam bit                HAS_B   = (NUM_CTR > 1);

   logic wr_a, wr_b;
   assign wr_a = reg_wr && (reg_addr == A_CNT_A);
   assign wr_b = reg_wr && (reg_addr == A_CNT_B);

   a_r2_gctl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_GCTL) |=> (glb_en == $past(reg_wdata[NUM_CTR-1:0])));

   a_r2_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en[0] && !wr_a) |=> $stable(cnt_a));

   a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a |=> ((cnt_a - $past(cnt_a)) <= CNT_W'(NUM_LANES)));

   a_r8_restricted_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_B && ctr0_only(sel_b[7:0]) && !wr_b) |=> $stable(cnt_b));

   a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && !(reg_wr && reg_addr == A_CLR && reg_wdata[0])) |=> status[0]);

   a_r11_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq);

endmodule

bind evt_counter_pair dpc_checker #(
   .NUM_LANES(NUM_LANES), .NUM_CTR(NUM_CTR), .CNT_W(CNT_W),
   .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .irq      (irq),
   .status   (status_q),
   .glb_en   (glb_en_q),
   .cnt_a    (cnt_val[0]),
   .cnt_b    (cnt_val[NUM_CTR-1]),
   .sel_b    (sel_q[NUM_CTR-1])
);

// File: tb/evt_counter_pair_bench.sv
`timescale 1ns/100ps
module evt_counter_pair_bench;

   localparam int NL = 4;
   localparam logic [7:0] A_C0 = 8'h20, A_C1 = 8'h21, A_S0 = 8'h28, A_S1 = 8'h29;
   localparam logic [7:0] A_ST = 8'h2d, A_CL = 8'h2e, A_GC = 8'h2f;
   localparam logic [63:0] ALL40 = 64'hFF_FFFF_FFFF;

   typedef struct packed {
      logic [7:0] thr;
      logic       inv;
      logic       edg;
      logic [2:0] p0, p1, p2, p3, p4;
      logic [7:0] exp;
   } vec_t;

   // Lane pattern per cycle: 3,1,4,0,2 matching lanes
   localparam vec_t TBL [8] = '{
      '{8'd0, 1'b0, 1'b0, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd10},
      '{8'd2, 1'b0, 1'b0, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd3},
      '{8'd2, 1'b1, 1'b0, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd2},
      '{8'd1, 1'b0, 1'b1, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd2},
      '{8'd4, 1'b0, 1'b0, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd1},
      '{8'd1, 1'b1, 1'b1, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd1},
      '{8'd3, 1'b1, 1'b0, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd3},
      '{8'd0, 1'b1, 1'b1, 3'd3, 3'd1, 3'd4, 3'd0, 3'd2, 8'd10}
   };

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [NL-1:0] lane_vld = '0;
   logic [NL*8-1:0] lane_code = '0, lane_umask = '0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [63:0]   reg_wdata = '0, reg_rdata, rv;
   logic          irq;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   evt_counter_pair u_evt_counter_pair (
      .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_code(lane_code),
      .lane_umask(lane_umask), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic drive(input int n, input logic [7:0] c, input logic [7:0] u);
      for (int l = 0; l < NL; l++) begin
         lane_vld[l]        = (l < n);
         lane_code[l*8+:8]  = c;
         lane_umask[l*8+:8] = u;
      end
   endtask

   function automatic logic [63:0] mksel(input logic [7:0] code, input logic [7:0] thr,
                                         input logic inv, input logic edg,
                                         input logic en, input logic ie);
      return {32'd0, thr, inv, en, 1'b0, ie, 1'b0, edg, 2'b00, 8'h5a, code};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_C0, rv); check("R1 cnt0", rv, 64'd0);
      rd(A_C1, rv); check("R1 cnt1", rv, 64'd0);
      rd(A_S0, rv); check("R1 sel0", rv, 64'd0);
      rd(A_ST, rv); check("R1 status", rv, 64'd0);
      rd(A_GC, rv); check("R1 gctl", rv, 64'd0);
      check("R1 irq", {63'd0, irq}, 64'd0);

      // Table walk: R5 R6 R7 qualification modes
      for (int v = 0; v < 8; v++) begin
         logic [2:0] pat [5];
         string tag;
         pat = '{TBL[v].p0, TBL[v].p1, TBL[v].p2, TBL[v].p3, TBL[v].p4};
         tag = (TBL[v].thr == 0) ? "R5 raw" : (TBL[v].edg ? "R7 edge" : "R6 thresh");
         wr(A_GC, 64'd0);
         wr(A_C0, 64'd0);
         wr(A_S0, mksel(8'h42, TBL[v].thr, TBL[v].inv, TBL[v].edg, 1'b1, 1'b0));
         wr(A_GC, 64'd1);
         for (int k = 0; k < 5; k++) begin
            drive(int'(pat[k]), 8'h42, 8'h5a);
            if (k == 4) begin reg_wr = 1'b1; reg_addr = A_GC; reg_wdata = 64'd0; end
            @(negedge clk);
         end
         reg_wr = 1'b0;
         drive(0, 8'h00, 8'h00);
         rd(A_C0, rv); check(tag, rv, {56'd0, TBL[v].exp});
      end

      // R4 lane matching on code and unit mask
      wr(A_C0, 64'd0);
      wr(A_S0, mksel(8'h42, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      rd(A_S0, rv); check("R4 sel readback", rv, mksel(8'h42, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      wr(A_GC, 64'd1);
      lane_vld = 4'b0111;
      lane_code  = {8'h42, 8'h43, 8'h42, 8'h42};
      lane_umask = {8'h5a, 8'h5a, 8'h33, 8'h5a};
      @(negedge clk);
      drive(0, 8'h00, 8'h00);
      rd(A_C0, rv); check("R4 match", rv, 64'd1);

      // R2 local and global enables
      wr(A_S0, mksel(8'h42, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      drive(2, 8'h42, 8'h5a); repeat (3) @(negedge clk); drive(0, 8'h00, 8'h00);
      rd(A_C0, rv); check("R2 local off", rv, 64'd1);
      wr(A_S0, mksel(8'h42, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      wr(A_GC, 64'd0);
      drive(2, 8'h42, 8'h5a); repeat (3) @(negedge clk); drive(0, 8'h00, 8'h00);
      rd(A_C0, rv); check("R2 global off", rv, 64'd1);

      // R8 codes restricted to counter 0
      wr(A_GC, 64'd3);
      wr(A_S0, mksel(8'hcb, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      wr(A_S1, mksel(8'hcb, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      wr(A_C0, 64'd0);
      wr(A_C1, 64'd0);
      drive(1, 8'hcb, 8'h5a); repeat (3) @(negedge clk); drive(0, 8'h00, 8'h00);
      rd(A_C1, rv); check("R8 ctr1 held", rv, 64'd0);
      rd(A_C0, rv); check("R8 ctr0 counts", rv, 64'd3);
      wr(A_S1, mksel(8'hcd, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      drive(1, 8'hcd, 8'h5a); repeat (3) @(negedge clk); drive(0, 8'h00, 8'h00);
      rd(A_C1, rv); check("R8 ctr1 other code", rv, 64'd3);

      // R3 write masking and write priority
      wr(A_GC, 64'd0);
      wr(A_C1, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_C1, rv); check("R3 mask", rv, ALL40);
      wr(A_S0, mksel(8'h42, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      wr(A_GC, 64'd1);
      drive(2, 8'h42, 8'h5a);
      wr(A_C0, 64'd5);
      drive(0, 8'h00, 8'h00);
      rd(A_C0, rv); check("R3 write wins", rv, 64'd5);

      // R9 R11 overflow with interrupt
      wr(A_GC, 64'd0);
      wr(A_S0, mksel(8'h42, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1));
      wr(A_C0, ALL40 - 64'd1);
      wr(A_GC, 64'd1);
      drive(3, 8'h42, 8'h5a); @(negedge clk); drive(0, 8'h00, 8'h00);
      rd(A_C0, rv); check("R9 wrap value", rv, 64'd1);
      rd(A_ST, rv); check("R9 status", rv, 64'd1);
      check("R11 irq high", {63'd0, irq}, 64'd1);
      wr(A_ST, 64'd0);
      rd(A_ST, rv); check("R9 status write ignored", rv, 64'd1);

      // R10 clear
      wr(A_CL, 64'd1);
      rd(A_ST, rv); check("R10 cleared", rv, 64'd0);
      check("R11 irq low", {63'd0, irq}, 64'd0);
      rd(A_CL, rv); check("R10 reads zero", rv, 64'd0);

      // R10 overflow and clear in the same cycle
      wr(A_C0, ALL40);
      drive(1, 8'h42, 8'h5a);
      reg_wr = 1'b1; reg_addr = A_CL; reg_wdata = 64'd1;
      @(negedge clk);
      reg_wr = 1'b0;
      drive(0, 8'h00, 8'h00);
      rd(A_ST, rv); check("R10 overflow wins", rv, 64'd1);
      rd(A_C0, rv); check("R9 wrap to zero", rv, 64'd0);
      wr(A_CL, 64'd1);

      // R11 overflow without interrupt enable
      wr(A_GC, 64'd3);
      wr(A_C1, ALL40);
      drive(1, 8'hcd, 8'h5a); @(negedge clk); drive(0, 8'h00, 8'h00);
      rd(A_ST, rv); check("R9 status ctr1", rv, 64'd2);
      check("R11 irq masked", {63'd0, irq}, 64'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule